// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits at the front of an Ethernet receive path and decides, from the destination address alone, whether the frame that is arriving should be kept. The address arrives one byte per cycle, marked by a byte-valid qualifier. The first byte received lands in the lowest byte of the address. Within each byte, bit 0 is the bit that came first on the wire. A frame-start strobe resets the byte count and the hash state, so each new frame begins cleanly.

Three kinds of address are told apart. An address of all ones is a broadcast. It is judged only by the broadcast-disable and promiscuous controls. An address with bit 0 set that is not all ones is a group (multicast) address. A CRC-32 is run over its 48 bits, and the top six bits of that CRC pick one bit of a 64-bit hash filter. An address with bit 0 clear is an individual address, and it is compared with the 48-bit node address. Promiscuous mode accepts everything. The verdict appears as a one-cycle pulse on the cycle after the sixth address byte is taken.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `res_valid` and `res_accept` are both low, and no verdict is produced until six address bytes have been taken.
- R2: Byte k of the address (k = 0 first) fills address bits [8k+7:8k]. When address bit 0 is 0 and all 48 bits equal `node_addr`, the frame is accepted.
- R3: An address with bit 0 equal to 0 that differs from `node_addr` in any bit is rejected when `promisc` is low.
- R4: The all-ones address is accepted when `bcast_off` is low, whatever the hash filter holds.
- R5: The all-ones address with `bcast_off` high is accepted if `promisc` is high and rejected if `promisc` is low. The hash filter plays no part, even when it is all ones.
- R6: For an address with bit 0 equal to 1 that is not all ones, the CRC is computed as follows. The register is preset to 0xFFFFFFFF and uses polynomial 0x04C11DB7. Bits are fed in wire order (byte 0 first, LSB first in each byte), with feedback = crc[31] XOR the incoming bit. The result is not inverted. The frame is accepted exactly when `hash_filter[crc[31:26]]` is 1.
- R7: With `hash_filter` all zeros and `promisc` low, every group address is rejected.
- R8: With `promisc` high, every address is accepted.
- R9: `res_valid` pulses for exactly one cycle, on the cycle after the sixth byte is taken. `res_accept` is low whenever `res_valid` is low.
- R10: `frame_start` clears the byte count and presets the CRC. A byte presented in the same cycle counts as byte 0 of the new frame. A partial address cut short by `frame_start` yields no verdict.
- R11: Bytes offered after the sixth, until the next `frame_start`, are ignored and produce no further verdict.
- R12: The configuration inputs are sampled in the cycle the sixth byte is taken. Changes after that cycle do not alter the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | New-frame strobe; restarts byte count and CRC |
| byte_valid | input | 1 | `byte_data` carries an address byte this cycle |
| byte_data | input | 8 | Address byte, bit 0 first on the wire |
| node_addr | input | 48 | Node address for the individual-address compare |
| hash_filter | input | 64 | Group-address hash filter, indexed by the CRC select |
| promisc | input | 1 | Accept every frame |
| bcast_off | input | 1 | Reject broadcast unless promiscuous |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
Two functions can land on the same cycle. One is the restart on `frame_start`. The other is the capture of a byte: `byte_valid` is high together with the strobe, so that byte must become byte 0 of the new frame, not be dropped or appended to the old one. The bench sends whole frames in both forms, with the strobe alone and with the strobe merged onto the first byte. It also aborts a half-sent address with a merged restart, then checks that exactly one verdict arrives and that it is the one computed in the bench for the new address. Around this, the bench sweeps one-hot hash filters against several group addresses and flips every bit of the node address one at a time.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      KIND_UCAST = 2'd0,
      KIND_MCAST = 2'd1,
      KIND_BCAST = 2'd2
   } addr_kind_e;

endpackage

// File: rtl/rxf_byte_collect.sv
module rxf_byte_collect #(
   parameter int BYTES  = 6,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = $clog2(BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    byte_valid,
   input  logic [BYTE_W-1:0]       byte_data,
   output logic                    take,
   output logic                    last,
   output logic [BYTES*BYTE_W-1:0] addr_next
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_eff;
   logic [CNT_W-1:0] cnt_d;

   assign cnt_eff = frame_start ? '0 : cnt_q;
   assign take    = byte_valid && (cnt_eff < CNT_W'(BYTES));
   assign last    = take && (cnt_eff == CNT_W'(BYTES - 1));
   assign cnt_d   = take ? cnt_eff + CNT_W'(1) : cnt_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   for (genvar k = 0; k < BYTES; k++) begin : g_lane
      logic [BYTE_W-1:0] lane_q;
      logic              wr;
      assign wr = take && (cnt_eff == CNT_W'(k));
      assign addr_next[k*BYTE_W +: BYTE_W] = wr ? byte_data : lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  lane_q <= '0;
         else if (wr) lane_q <= byte_data;
      end
   end

   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BYTES));

   a_r10_merged_start: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && byte_valid) |=> (cnt_q == CNT_W'(1)));

   a_r11_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && cnt_q == CNT_W'(BYTES)) |-> !take);

endmodule

// File: rtl/rxf_crc_step.sv
module rxf_crc_step #(
   parameter int               CRC_W     = 32,
   parameter int               DATA_W    = 8,
   parameter logic [CRC_W-1:0] POLY      = 32'h04C11DB7,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc_out
);

   logic [CRC_W-1:0] chain [DATA_W+1];

   assign chain[0] = crc_in;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic din;
      if (LSB_FIRST) begin : g_lsb
         assign din = data[i];
      end else begin : g_msb
         assign din = data[DATA_W-1-i];
      end
      logic fb;
      assign fb = chain[i][CRC_W-1] ^ din;
      assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   assign crc_out = chain[DATA_W];

endmodule

// File: rtl/rxf_hash_unit.sv
module rxf_hash_unit #(
   parameter int               CRC_W     = 32,
   parameter int               BYTE_W    = 8,
   parameter int               HASH_BITS = 6,
   parameter logic [CRC_W-1:0] POLY      = 32'h04C11DB7,
   parameter logic [CRC_W-1:0] INIT      = '1,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_start,
   input  logic                 take,
   input  logic [BYTE_W-1:0]    byte_data,
   output logic [HASH_BITS-1:0] sel_next
);

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_base;
   logic [CRC_W-1:0] crc_stepped;

   assign crc_base = frame_start ? INIT : crc_q;

   rxf_crc_step #(
      .CRC_W     (CRC_W),
      .DATA_W    (BYTE_W),
      .POLY      (POLY),
      .LSB_FIRST (LSB_FIRST)
   ) u_step (
      .crc_in  (crc_base),
      .data    (byte_data),
      .crc_out (crc_stepped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc_q <= INIT;
      else        crc_q <= take ? crc_stepped : crc_base;
   end

   assign sel_next = crc_stepped[CRC_W-1 -: HASH_BITS];

   a_r10_crc_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !take) |=> (crc_q == INIT));

   a_r11_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !take) |=> $stable(crc_q));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6,
   parameter int FILT_W    = 1 << HASH_BITS
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [HASH_BITS-1:0] sel,
   input  logic [ADDR_W-1:0]    node_addr,
   input  logic [FILT_W-1:0]    hash_filter,
   input  logic                 promisc,
   input  logic                 bcast_off,
   output addr_kind_e           kind,
   output logic                 accept
);

   logic hit;

   always_comb begin
      if (&addr)        kind = KIND_BCAST;
      else if (addr[0]) kind = KIND_MCAST;
      else              kind = KIND_UCAST;
   end

   always_comb begin
      unique case (kind)
         KIND_BCAST: hit = !bcast_off;
         KIND_MCAST: hit = hash_filter[sel];
         default:    hit = (addr == node_addr);
      endcase
   end

   assign accept = promisc | hit;

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int                 BYTE_W     = 8,
   parameter int                 ADDR_BYTES = 6,
   parameter int                 CRC_W      = 32,
   parameter logic [CRC_W-1:0]   CRC_POLY   = 32'h04C11DB7,
   parameter logic [CRC_W-1:0]   CRC_INIT   = '1,
   parameter int                 HASH_BITS  = 6,
   parameter bit                 LSB_FIRST  = 1'b1,
   localparam int                ADDR_W     = ADDR_BYTES * BYTE_W,
   localparam int                FILT_W     = 1 << HASH_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [ADDR_W-1:0] node_addr,
   input  logic [FILT_W-1:0] hash_filter,
   input  logic              promisc,
   input  logic              bcast_off,
   output logic              res_valid,
   output logic              res_accept
);

   localparam int CNT_W = $clog2(ADDR_BYTES + 1);

   if (HASH_BITS < 1 || HASH_BITS > CRC_W) begin : g_bad_hash
      $error("HASH_BITS must lie between 1 and CRC_W");
   end
   if (ADDR_BYTES < 2) begin : g_bad_bytes
      $error("ADDR_BYTES must be at least 2");
   end
   if (CRC_W < 2) begin : g_bad_crc
      $error("CRC_W must be at least 2");
   end

   logic                 take;
   logic                 last;
   logic [ADDR_W-1:0]    addr_next;
   logic [HASH_BITS-1:0] sel_next;
   addr_kind_e           kind;
   logic                 accept;

   rxf_byte_collect #(
      .BYTES  (ADDR_BYTES),
      .BYTE_W (BYTE_W),
      .CNT_W  (CNT_W)
   ) u_collect (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .byte_valid  (byte_valid),
      .byte_data   (byte_data),
      .take        (take),
      .last        (last),
      .addr_next   (addr_next)
   );

   rxf_hash_unit #(
      .CRC_W     (CRC_W),
      .BYTE_W    (BYTE_W),
      .HASH_BITS (HASH_BITS),
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .LSB_FIRST (LSB_FIRST)
   ) u_hash (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .take        (take),
      .byte_data   (byte_data),
      .sel_next    (sel_next)
   );

   rxf_decide #(
      .ADDR_W    (ADDR_W),
      .HASH_BITS (HASH_BITS),
      .FILT_W    (FILT_W)
   ) u_decide (
      .addr        (addr_next),
      .sel         (sel_next),
      .node_addr   (node_addr),
      .hash_filter (hash_filter),
      .promisc     (promisc),
      .bcast_off   (bcast_off),
      .kind        (kind),
      .accept      (accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
      end else begin
         res_valid  <= last;
         res_accept <= last && accept;
      end
   end

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   a_r9_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !res_accept);

   a_r8_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (last && promisc) |=> res_accept);

   a_r5_bcast_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (last && kind == KIND_BCAST && bcast_off && !promisc) |=> !res_accept);

   a_r7_zero_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (last && kind == KIND_MCAST && hash_filter == '0 && !promisc) |=> !res_accept);

   a_r2_node_match: assert property (@(posedge clk) disable iff (!rst_n)
      (last && kind == KIND_UCAST && addr_next == node_addr) |=> res_accept);

endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic [47:0] node_addr = 48'h5A_34_12_90_78_56;
   logic [63:0] hash_filter = '0;
   logic        promisc = 1'b0;
   logic        bcast_off = 1'b0;
   logic        res_valid;
   logic        res_accept;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   rx_addr_filter u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .byte_valid  (byte_valid),
      .byte_data   (byte_data),
      .node_addr   (node_addr),
      .hash_filter (hash_filter),
      .promisc     (promisc),
      .bcast_off   (bcast_off),
      .res_valid   (res_valid),
      .res_accept  (res_accept)
   );

   function automatic logic [5:0] ref_sel(input logic [47:0] a);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb;
         fb = c[31] ^ a[i];
         c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
      return c[31:26];
   endfunction

   function automatic logic ref_accept(input logic [47:0] a);
      if (promisc)      return 1'b1;
      if (&a)           return !bcast_off;
      if (a[0])         return hash_filter[ref_sel(a)];
      return a == node_addr;
   endfunction

   task automatic chk(input logic ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_frame(input logic [47:0] a, input bit merge, input string tag);
      logic exp_acc;
      int   first;
      @(negedge clk);
      frame_start = 1'b1;
      if (merge) begin
         byte_valid = 1'b1;
         byte_data  = a[7:0];
         first      = 1;
      end else begin
         byte_valid = 1'b0;
         first      = 0;
      end
      for (int k = first; k < 6; k++) begin
         @(negedge clk);
         frame_start = 1'b0;
         byte_valid  = 1'b1;
         byte_data   = a[8*k +: 8];
      end
      exp_acc = ref_accept(a);
      @(negedge clk);
      byte_valid = 1'b0;
      chk(res_valid === 1'b1, {tag, " R9 valid"}, 64'(res_valid), 64'd1);
      chk(res_accept === exp_acc, tag, 64'(res_accept), 64'(exp_acc));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [47:0] mc [8];
      int hits;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(res_valid === 1'b0, "R1 valid", 64'(res_valid), 64'd0);
      chk(res_accept === 1'b0, "R1 accept", 64'(res_accept), 64'd0);

      // R2: node address match, both start forms
      send_frame(node_addr, 1'b0, "R2 match");
      send_frame(node_addr, 1'b1, "R2 match merged");
      @(negedge clk);
      chk(res_valid === 1'b0, "R9 pulse ends", 64'(res_valid), 64'd0);

      // R3: every single-bit difference from the node address
      for (int b = 0; b < 48; b++)
         send_frame(node_addr ^ (48'd1 << b), b[0], "R3 flip");

      // R4 / R5: broadcast rules; filter must not matter
      for (int p = 0; p < 2; p++)
         for (int d = 0; d < 2; d++)
            for (int f = 0; f < 2; f++) begin
               promisc     = p[0];
               bcast_off   = d[0];
               hash_filter = f[0] ? '1 : '0;
               send_frame('1, 1'b0, d[0] ? "R5 bcast" : "R4 bcast");
            end
      promisc = 1'b0; bcast_off = 1'b0;

      // R6: one-hot hash filter sweep, group addresses
      for (int m = 0; m < 8; m++)
         mc[m] = {8'(m * 37 + 3), 32'h1357_9BDF ^ 32'(m * 32'h0101_0F21), 8'(m * 2 + 1)};
      for (int m = 0; m < 8; m++) begin
         hits = 0;
         for (int s = 0; s < 64; s++) begin
            hash_filter = 64'd1 << s;
            send_frame(mc[m], (s % 3) == 0, "R6 hash");
            if (res_accept === 1'b1) hits++;
         end
         chk(hits == 1, "R6 single hit", 64'(hits), 64'd1);
      end

      // R7: zero filter rejects group addresses
      hash_filter = '0;
      for (int m = 0; m < 8; m++) send_frame(mc[m], 1'b0, "R7 zero filter");

      // R8: promiscuous accepts all kinds
      promisc = 1'b1; bcast_off = 1'b1;
      send_frame(mc[0], 1'b0, "R8 group");
      send_frame(node_addr ^ 48'h10, 1'b0, "R8 other node");
      send_frame('1, 1'b0, "R8 bcast");
      promisc = 1'b0; bcast_off = 1'b0;

      // R11: bytes past the sixth are ignored
      send_frame(node_addr, 1'b0, "R11 base");
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         byte_valid = 1'b1;
         byte_data  = 8'(k);
         chk(res_valid === 1'b0, "R11 no extra verdict", 64'(res_valid), 64'd0);
      end
      @(negedge clk);
      byte_valid = 1'b0;
      chk(res_valid === 1'b0, "R11 no extra verdict", 64'(res_valid), 64'd0);

      // R10: abort after three bytes, restart merged with a byte
      @(negedge clk);
      frame_start = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         frame_start = 1'b0;
         byte_valid  = 1'b1;
         byte_data   = node_addr[8*k +: 8];
      end
      hash_filter = 64'd1 << ref_sel(mc[5]);
      send_frame(mc[5], 1'b1, "R10 restart");
      @(negedge clk);
      chk(res_valid === 1'b0, "R10 one verdict", 64'(res_valid), 64'd0);

      // R12: config sampled at sixth byte
      bcast_off = 1'b1; promisc = 1'b0;
      @(negedge clk);
      frame_start = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         frame_start = 1'b0;
         byte_valid  = 1'b1;
         byte_data   = 8'hFF;
         promisc     = (k == 5);
      end
      @(negedge clk);
      byte_valid = 1'b0;
      promisc    = 1'b0;
      #1;
      chk(res_accept === 1'b1, "R12 sampled at sixth byte", 64'(res_accept), 64'd1);
      bcast_off = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule